// File: doc/BRIEF.md
# Signed BCD Binary Converter

This block translates signed integers between two's complement binary and a signed packed decimal form, in either direction and at either of two word sizes. In the packed decimal form each four-bit group holds one decimal digit, the least significant digit sits in bits 3:0, and the top nibble of the word is a sign field (4'h0 for positive, 4'hF for negative). The 16-bit word carries three digits (range -999..+999); the 32-bit word carries seven (range -9999999..+9999999).

A two-bit function select picks the operation: bit 0 gives the direction (0 = binary to BCD, 1 = BCD to binary) and bit 1 gives the size (0 = 16-bit, 1 = 32-bit). When the enable input is sampled high, the result, an enable-out status and an invalid-input flag are registered on that clock edge. Enable-out low after a binary-to-BCD request means the value did not fit; BCD-to-binary cannot overflow, but a malformed BCD word raises the invalid flag.

Top module: `bcd_bin_conv`

## Requirements
- R1: After reset, dataOut is 0, enOut is 0 and invalidOut is 0.
- R2: With funcSel = 2'b00, dataIn[15:0] is read as a signed 16-bit value and dataOut becomes {16'h0, sign, d2, d1, d0}, sign 4'h0 for positive or zero and 4'hF for negative, d0 in bits 3:0; enOut is 1.
- R3: With funcSel = 2'b10, dataIn is read as a signed 32-bit value and dataOut becomes {sign, d6..d0} with the sign nibble in bits 31:28; enOut is 1.
- R4: A binary-to-BCD request whose magnitude exceeds 999 (16-bit) or 9999999 (32-bit) gives enOut = 0 and dataOut = 0.
- R5: With funcSel = 2'b01 or 2'b11, the BCD input is converted to two's complement at the selected width (sign nibble in bits 15:12 or 31:28); in the 16-bit mode dataOut[31:16] is 0; enOut is 1.
- R6: A BCD-to-binary request with any digit nibble above 9, or a sign nibble other than 4'h0 or 4'hF, gives invalidOut = 1, dataOut = 0 and enOut = 1.
- R7: While enIn is low, dataOut keeps its value and enOut and invalidOut are 0 at the next edge.
- R8: All outputs reflect a request one clock edge after enIn is sampled high.
- R9: In the 16-bit modes dataIn[31:16] has no effect on any output.
- R10: invalidOut is never set by a binary-to-BCD request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| enIn | input | 1 | Request strobe; a conversion is taken on each edge where it is high |
| funcSel | input | 2 | bit 0 direction (1 = BCD to binary), bit 1 size (1 = 32-bit) |
| dataIn | input | 32 | Operand; 16-bit modes use bits 15:0 only |
| dataOut | output | 32 | Registered result |
| enOut | output | 1 | Registered status: 1 = result valid, 0 = idle or overflow |
| invalidOut | output | 1 | Registered flag: malformed BCD operand |

## Verification
A wrong digit in the double-dabble path or in the weighted sum shows as a wrong nibble or value on dataOut one edge after the request, so each directed value is chosen to exercise distinct digits, both signs and the exact range limits. A faulty range comparison shows as enOut high with a nonzero result just beyond the limit, or low just inside it. A result register that loads when it should not shows as dataOut changing while enIn is low, observed over two idle edges after a new operand is presented.

// File: rtl/bcd_conv_pkg.sv
package bcd_conv_pkg;

  typedef struct packed {
    logic loadRes;   // capture a new result this edge
    logic bcdToBin;  // direction: 1 = decimal to binary
    logic wide;      // size: 1 = 32-bit word
  } convStrobes_t;

  localparam logic [3:0] SIGN_POS = 4'h0;
  localparam logic [3:0] SIGN_NEG = 4'hF;

  function automatic longint unsigned maxDecimal(input int digits);
    longint unsigned v;
    v = 1;
    for (int i = 0; i < digits; i++) v = v * 10;
    return v - 1;
  endfunction

endpackage

// File: rtl/bcd_conv_ctrl.sv
module bcd_conv_ctrl
  import bcd_conv_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enIn,
  input  logic [1:0]   funcSel,
  input  logic         overflow,
  input  logic         badDigit,
  output convStrobes_t strobes,
  output logic         enOut,
  output logic         invalidOut
);

  logic enNext;
  logic invNext;

  always_comb begin
    strobes.loadRes  = enIn;
    strobes.bcdToBin = funcSel[0];
    strobes.wide     = funcSel[1];
    enNext  = enIn && (funcSel[0] || !overflow);
    invNext = enIn && funcSel[0] && badDigit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enOut      <= 1'b0;
      invalidOut <= 1'b0;
    end else begin
      enOut      <= enNext;
      invalidOut <= invNext;
    end
  end

  // R7: idle request clears both flags at the next edge
  a_r7_idle_flags: assert property (@(posedge clk) disable iff (!rstN)
    !enIn |=> (!enOut && !invalidOut));

  // R5: decimal-to-binary never reports overflow
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (enIn && funcSel[0]) |=> enOut);

  // R10: binary-to-decimal never raises the invalid flag
  a_r10_bin_valid: assert property (@(posedge clk) disable iff (!rstN)
    (enIn && !funcSel[0]) |=> !invalidOut);

endmodule

// File: rtl/bcd_conv_datapath.sv
module bcd_conv_datapath
  import bcd_conv_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  convStrobes_t      strobes,
  input  logic [WIDE_W-1:0] dataIn,
  output logic [WIDE_W-1:0] resultQ,
  output logic              overflow,
  output logic              badDigit
);

  localparam int NARROW_DIGITS = NARROW_W / 4 - 1;
  localparam int WIDE_DIGITS   = WIDE_W / 4 - 1;
  localparam int DIG_BITS      = WIDE_DIGITS * 4;
  localparam longint unsigned NARROW_MAX = maxDecimal(NARROW_DIGITS);
  localparam longint unsigned WIDE_MAX   = maxDecimal(WIDE_DIGITS);
  localparam int MAG_W = $clog2(WIDE_MAX + 1);
  localparam logic [WIDE_W:0] NARROW_LIM = (WIDE_W+1)'(NARROW_MAX);
  localparam logic [WIDE_W:0] WIDE_LIM   = (WIDE_W+1)'(WIDE_MAX);

  // ---------------- binary to decimal ----------------
  logic [WIDE_W:0]   binVal;
  logic              binNeg;
  logic [WIDE_W:0]   binMag;
  logic [DIG_BITS-1:0] digits;
  logic [3:0]        binSign;
  logic [WIDE_W-1:0] bcdWord;

  function automatic logic [DIG_BITS-1:0] dabble(input logic [MAG_W-1:0] mag);
    logic [DIG_BITS-1:0] acc;
    acc = '0;
    for (int b = MAG_W - 1; b >= 0; b--) begin
      for (int d = 0; d < WIDE_DIGITS; d++) begin
        if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
      end
      acc = {acc[DIG_BITS-2:0], mag[b]};
    end
    return acc;
  endfunction

  always_comb begin
    if (strobes.wide)
      binVal = {dataIn[WIDE_W-1], dataIn};
    else
      binVal = {{(WIDE_W-NARROW_W+1){dataIn[NARROW_W-1]}}, dataIn[NARROW_W-1:0]};
    binNeg   = binVal[WIDE_W];
    binMag   = binNeg ? (~binVal + 1'b1) : binVal;
    overflow = binMag > (strobes.wide ? WIDE_LIM : NARROW_LIM);
    digits   = dabble(binMag[MAG_W-1:0]);
    binSign  = binNeg ? SIGN_NEG : SIGN_POS;
    if (strobes.wide)
      bcdWord = {binSign, digits};
    else
      bcdWord = {{(WIDE_W-NARROW_W){1'b0}}, binSign, digits[NARROW_DIGITS*4-1:0]};
  end

  // ---------------- decimal to binary ----------------
  logic [3:0]        signNib;
  logic [WIDE_W-1:0] accum;
  logic [WIDE_W-1:0] signedVal;
  logic [WIDE_W-1:0] binWord;
  logic              nibBad;

  always_comb begin
    signNib = strobes.wide ? dataIn[WIDE_W-1 -: 4] : dataIn[NARROW_W-1 -: 4];
    nibBad  = 1'b0;
    accum   = '0;
    for (int d = WIDE_DIGITS - 1; d >= 0; d--) begin
      if (strobes.wide || d < NARROW_DIGITS) begin
        if (dataIn[d*4 +: 4] > 4'd9) nibBad = 1'b1;
        accum = accum * WIDE_W'(10) + WIDE_W'(dataIn[d*4 +: 4]);
      end
    end
    badDigit  = nibBad || !(signNib == SIGN_POS || signNib == SIGN_NEG);
    signedVal = (signNib == SIGN_NEG) ? (~accum + 1'b1) : accum;
    if (strobes.wide)
      binWord = signedVal;
    else
      binWord = {{(WIDE_W-NARROW_W){1'b0}}, signedVal[NARROW_W-1:0]};
  end

  // ---------------- result register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      resultQ <= '0;
    else if (strobes.loadRes) begin
      if (strobes.bcdToBin)
        resultQ <= badDigit ? '0 : binWord;
      else
        resultQ <= overflow ? '0 : bcdWord;
    end
  end

  // R7: the result register holds while no request is presented
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadRes |=> $stable(resultQ));

  // R2: narrow modes leave the upper half of the result clear
  a_r2_narrow_upper: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadRes && !strobes.wide) |=> (resultQ[WIDE_W-1:NARROW_W] == '0));

endmodule

// File: rtl/bcd_bin_conv.sv
module bcd_bin_conv
  import bcd_conv_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enIn,
  input  logic [1:0]        funcSel,
  input  logic [WIDE_W-1:0] dataIn,
  output logic [WIDE_W-1:0] dataOut,
  output logic              enOut,
  output logic              invalidOut
);

  convStrobes_t strobes;
  logic overflow;
  logic badDigit;

  bcd_conv_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enIn       (enIn),
    .funcSel    (funcSel),
    .overflow   (overflow),
    .badDigit   (badDigit),
    .strobes    (strobes),
    .enOut      (enOut),
    .invalidOut (invalidOut)
  );

  bcd_conv_datapath #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dataIn   (dataIn),
    .resultQ  (dataOut),
    .overflow (overflow),
    .badDigit (badDigit)
  );

  // R6: a malformed operand always leaves a zero result
  a_r6_invalid_zero: assert property (@(posedge clk) disable iff (!rstN)
    invalidOut |-> (dataOut == '0));

  // R4: a binary request that reports failure leaves a zero result
  a_r4_overflow_zero: assert property (@(posedge clk) disable iff (!rstN)
    (enIn && !funcSel[0]) |=> (enOut || dataOut == '0));

endmodule

// File: tb/sim_bcd_bin_conv.sv
module sim_bcd_bin_conv;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enIn = 1'b0;
  logic [1:0]  funcSel = 2'b00;
  logic [31:0] dataIn = '0;
  logic [31:0] dataOut;
  logic        enOut;
  logic        invalidOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_bin_conv u0 (
    .clk(clk), .rstN(rstN), .enIn(enIn), .funcSel(funcSel),
    .dataIn(dataIn), .dataOut(dataOut), .enOut(enOut), .invalidOut(invalidOut)
  );

  task automatic check(input string tag, input logic [31:0] res, input logic en,
                       input logic inv);
    checks++;
    if (dataOut !== res || enOut !== en || invalidOut !== inv) begin
      errors++;
      $display("FAIL %s: actual out=%h en=%b inv=%b expected out=%h en=%b inv=%b",
               tag, dataOut, enOut, invalidOut, res, en, inv);
    end
  endtask

  // one request, sampled at the negedge after the capturing edge (R8)
  task automatic convert(input string tag, input logic [1:0] f, input logic [31:0] d,
                         input logic [31:0] res, input logic en, input logic inv);
    @(negedge clk);
    funcSel = f; dataIn = d; enIn = 1'b1;
    @(negedge clk);
    enIn = 1'b0;
    check(tag, res, en, inv);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 reset", 32'h0, 1'b0, 1'b0);
  endtask

  task automatic testBinNarrow();
    convert("R2 +123",   2'b00, 32'h0000_007B, 32'h0000_0123, 1, 0);
    convert("R2 -45",    2'b00, 32'h0000_FFD3, 32'h0000_F045, 1, 0);
    convert("R2 +999",   2'b00, 32'h0000_03E7, 32'h0000_0999, 1, 0);
    convert("R2 -999",   2'b00, 32'h0000_FC19, 32'h0000_F999, 1, 0);
    convert("R2 zero",   2'b00, 32'h0000_0000, 32'h0000_0000, 1, 0);
  endtask

  task automatic testBinWide();
    convert("R3 +9999999", 2'b10, 32'h0098_967F, 32'h0999_9999, 1, 0);
    convert("R3 -1234567", 2'b10, 32'hFFED_2979, 32'hF123_4567, 1, 0);
    convert("R3 +80",      2'b10, 32'h0000_0050, 32'h0000_0080, 1, 0);
  endtask

  task automatic testOverflow();
    convert("R4 +1000",     2'b00, 32'h0000_03E8, 32'h0, 0, 0);
    convert("R4 -1000",     2'b00, 32'h0000_FC18, 32'h0, 0, 0);
    convert("R4 -32768",    2'b00, 32'h0000_8000, 32'h0, 0, 0);
    convert("R4 +10000000", 2'b10, 32'h0098_9680, 32'h0, 0, 0);
    convert("R4 min32",     2'b10, 32'h8000_0000, 32'h0, 0, 0);
  endtask

  task automatic testBcdToBin();
    convert("R5 F123 narrow",  2'b01, 32'h0000_F123, 32'h0000_FF85, 1, 0);
    convert("R5 0999 narrow",  2'b01, 32'h0000_0999, 32'h0000_03E7, 1, 0);
    convert("R5 -9999999",     2'b11, 32'hF999_9999, 32'hFF67_6981, 1, 0);
    convert("R5 +1234567",     2'b11, 32'h0123_4567, 32'h0012_D687, 1, 0);
    convert("R5 negative zero",2'b11, 32'hF000_0000, 32'h0000_0000, 1, 0);
  endtask

  task automatic testInvalid();
    convert("R6 digit A",   2'b01, 32'h0000_012A, 32'h0, 1, 1);
    convert("R6 sign 5",    2'b01, 32'h0000_5123, 32'h0, 1, 1);
    convert("R6 wide d6=C", 2'b11, 32'h0C00_0001, 32'h0, 1, 1);
    convert("R6 then valid",2'b11, 32'h0000_0042, 32'h0000_002A, 1, 0);
  endtask

  task automatic testHold();
    convert("R7 setup", 2'b00, 32'h0000_0159, 32'h0000_0345, 1, 0);
    @(negedge clk);
    funcSel = 2'b11; dataIn = 32'h0000_0007;
    @(negedge clk);
    check("R7 hold cycle 1", 32'h0000_0345, 0, 0);
    @(negedge clk);
    check("R7 hold cycle 2", 32'h0000_0345, 0, 0);
  endtask

  task automatic testUpperIgnored();
    convert("R9 bin upper junk", 2'b00, 32'hABCD_0010, 32'h0000_0016, 1, 0);
    convert("R9 bcd upper junk", 2'b01, 32'hFFFF_0042, 32'h0000_002A, 1, 0);
    convert("R10 bin no invalid",2'b10, 32'h0000_00FF, 32'h0000_0255, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBinNarrow();
    testBinWide();
    testOverflow();
    testBcdToBin();
    testInvalid();
    testHold();
    testUpperIgnored();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule